// File: doc/BRIEF.md
# Edge-Triggered Display Status Interrupt Combiner

This block builds the status interrupt request for the display controller of a tile-based video unit. Four conditions can be enabled by the CPU: horizontal blank (mode 0), vertical blank (mode 1), object scan (mode 2), and scanline-equals-compare. Every enabled condition feeds one shared level line. The block sends a single-cycle request to the interrupt-flag logic only when that line rises from 0 to 1.

While the line is already high, a second condition that becomes active produces no request. The CPU acknowledging the interrupt does not clear the line. The line falls only when no enabled condition is active any more.

The line is evaluated on every dot-clock cycle. A condition that is active for only one cycle therefore still produces an edge. A CPU write to the enables or to the compare value acts on the line in the cycle after the write, and can raise it on its own. A read port returns the current mode, the coincidence flag, the enables and the compare value.

Top module: `stat_irq_combiner`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all four enables and the compare value read as 0 and irq_pulse_o is 0.
- R2: rd_status_o returns the current mode in bits 1:0 and the coincidence flag (line_i equal to the compare value) in bit 2. Bits 6:3 hold the enables in the order mode 0, mode 1, mode 2, coincidence, and bit 7 always reads 0.
- R3: A write with wr_sel_i = 0 loads the enables from wr_data_i[6:3] at the clock edge. wr_data_i bits 7 and 2:0 are ignored, so the read-only mode and coincidence fields are never changed by a write.
- R4: A write with wr_sel_i = 1 loads the compare value from wr_data_i at the clock edge, and rd_compare_o returns it. Without a write, the enables and the compare value hold their values.
- R5: The level line is the OR of the enabled conditions. Each mode condition is true when mode_i equals that mode, and the coincidence condition is true when line_i equals the compare value. With all enables clear, no request is ever raised.
- R6: irq_pulse_o is 1 in exactly those cycles where the level line is 1 and was 0 in the previous cycle. It is therefore never high for two consecutive cycles.
- R7: With the mode 0 and mode 2 conditions enabled, entering mode 0 raises one request, and a direct change from mode 0 to mode 2 raises none.
- R8: With only the mode 0 condition enabled, the sequence mode 2, mode 3, mode 0 raises exactly one request, on entry to mode 0.
- R9: A write that enables a condition which is already true raises a request in the cycle after the write edge.
- R10: A condition that is true for a single cycle, after a cycle with the line low, raises a request in that same cycle.
- R11: With all conditions enabled, the line stays high, and so raises no further request, until the mode is 3 and line_i differs from the compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Current display mode (0 hblank, 1 vblank, 2 object scan, 3 pixel transfer) |
| line_i | input | 8 | Current scanline counter |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status enables, 1 compare value |
| wr_data_i | input | 8 | Write data |
| rd_status_o | output | 8 | Status read value |
| rd_compare_o | output | 8 | Compare value read |
| irq_pulse_o | output | 1 | One-cycle interrupt request to the flag logic |

## Verification
The stored previous-level bit is the only hidden state, and it shows on irq_pulse_o alone. If that bit is wrong, either an extra request appears while another condition is still holding the line high, or an expected request is missing. Either error is visible in the first cycle in which any enabled condition changes. A wrong enable or compare value shows on the read ports in the cycle after the write edge, and shows in the request pattern from the next condition change onward. The bench therefore compares the pulse and both read ports against its own model on every cycle. It mixes random mode, line and write sequences with directed sequences for shared-line holding, single-cycle conditions and write-triggered edges.

// File: rtl/stat_irq_pkg.sv
// Package: shared widths, source indices and mode codes for the status
// interrupt combiner. Assumes a 2-bit mode code and an 8-bit scanline.
package stat_irq_pkg;
    localparam int LINE_W   = 8;
    localparam int MODE_W   = 2;
    localparam int NUM_SRC  = 4;
    localparam int NUM_MODE_SRC = 3;
    localparam int SRC_COIN = 3;
    localparam int EN_LSB   = 3;
    localparam int COIN_BIT = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_HBLANK = 2'd0,
        MODE_VBLANK = 2'd1,
        MODE_OSCAN  = 2'd2,
        MODE_XFER   = 2'd3
    } disp_mode_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/stat_cfg_regs.sv
// Configuration registers: holds the four source enables and the line
// compare value. Assumes a single write strobe with a select bit; the
// status write only touches the enable field.
module stat_cfg_regs
    import stat_irq_pkg::*;
#(
    parameter int DATA_W = LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output src_vec_t          en_o,
    output logic [DATA_W-1:0] cmp_o
);
    localparam int EN_MSB = EN_LSB + NUM_SRC - 1;

    src_vec_t          en_q;
    logic [DATA_W-1:0] cmp_q;

    // Enable register: loaded only by a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en_i && !wr_sel_i)
            en_q <= wr_data_i[EN_MSB:EN_LSB];
    end

    // Compare register: loaded only by a compare write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (wr_en_i && wr_sel_i)
            cmp_q <= wr_data_i;
    end

    assign en_o  = en_q;
    assign cmp_o = cmp_q;

    // R3
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_sel_i) |=> (en_o == $past(wr_data_i[EN_MSB:EN_LSB])));
    // R4
    cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i) |=> (cmp_o == $past(wr_data_i)));
    // R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(en_o) && $stable(cmp_o)));
endmodule

// File: rtl/stat_src_combine.sv
// Source combiner: evaluates each enabled condition for the current
// dot cycle and ORs them into the shared level. Purely combinational.
module stat_src_combine
    import stat_irq_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [LINE_W-1:0] cmp_i,
    input  src_vec_t          en_i,
    output logic              coin_o,
    output logic              level_o
);
    src_vec_t hit;

    // Per-mode match for each mode-driven source.
    for (genvar g = 0; g < NUM_MODE_SRC; g++) begin : g_mode_src
        assign hit[g] = en_i[g] && (mode_i == MODE_W'(g));
    end

    // Coincidence flag and its gated source.
    always_comb begin
        coin_o        = (line_i == cmp_i);
        hit[SRC_COIN] = en_i[SRC_COIN] && coin_o;
    end

    assign level_o = |hit;
endmodule

// File: rtl/stat_edge_det.sv
// Rising-edge detector: remembers last cycle's level and flags a 0-to-1
// change for exactly one cycle. Assumes it is clocked every dot cycle.
module stat_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic pulse_o
);
    logic prev_q;

    // Previous-level register; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= level_i;
    end

    assign pulse_o = rst_n && level_i && !prev_q;

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    // R6
    pulse_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> level_i);
endmodule

// File: rtl/stat_irq_combiner.sv
// Top: status interrupt combiner. Joins the configuration registers,
// the source combiner and the edge detector, and assembles the read
// value. Assumes mode and line inputs are synchronous to clk.
module stat_irq_combiner
    import stat_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [7:0]        line_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        rd_status_o,
    output logic [7:0]        rd_compare_o,
    output logic              irq_pulse_o
);
    src_vec_t          en;
    logic [LINE_W-1:0] cmp;
    logic              coin;
    logic              level;

    stat_cfg_regs #(.DATA_W(LINE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .en_o      (en),
        .cmp_o     (cmp)
    );

    stat_src_combine u_comb (
        .mode_i  (mode_i),
        .line_i  (line_i),
        .cmp_i   (cmp),
        .en_i    (en),
        .coin_o  (coin),
        .level_o (level)
    );

    stat_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level),
        .pulse_o (irq_pulse_o)
    );

    // Read value: mode, coincidence flag, enables; top bit reads zero.
    always_comb begin
        rd_status_o                   = '0;
        rd_status_o[MODE_W-1:0]       = mode_i;
        rd_status_o[COIN_BIT]         = coin;
        rd_status_o[EN_LSB+:NUM_SRC]  = en;
    end

    assign rd_compare_o = cmp;

    // R5
    no_src_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status_o[6:3] == 4'b0000) |-> !irq_pulse_o);
    // R2
    coin_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status_o[2] == (line_i == rd_compare_o));
endmodule

// File: tb/tb_stat_irq_combiner.sv
`timescale 1ns/1ps
module tb_stat_irq_combiner;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_i;
    logic [7:0] line_i;
    logic       wr_en_i;
    logic       wr_sel_i;
    logic [7:0] wr_data_i;
    logic [7:0] rd_status_o;
    logic [7:0] rd_compare_o;
    logic       irq_pulse_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Bench model state
    logic [3:0] m_en   = '0;
    logic [7:0] m_cmp  = '0;
    logic       m_prev = 1'b0;
    int         pulse_cnt = 0;

    always #2.5 clk = ~clk;

    stat_irq_combiner dut (.*);

    function automatic logic exp_level(logic [1:0] md, logic [7:0] ln,
                                       logic [3:0] en, logic [7:0] cmp);
        return (en[0] && md == 2'd0) || (en[1] && md == 2'd1) ||
               (en[2] && md == 2'd2) || (en[3] && ln == cmp);
    endfunction

    function automatic logic [7:0] exp_status(logic [1:0] md, logic [7:0] ln,
                                              logic [3:0] en, logic [7:0] cmp);
        return {1'b0, en, (ln == cmp), md};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One dot cycle: drive after negedge, check before posedge, update model.
    task automatic step(logic [1:0] md, logic [7:0] ln, logic we, logic sel,
                        logic [7:0] d, string ptag);
        logic lvl;
        logic exp_p;
        @(negedge clk);
        mode_i = md; line_i = ln; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
        #1;
        lvl   = exp_level(md, ln, m_en, m_cmp);
        exp_p = lvl && !m_prev;
        check({ptag, " pulse"}, {7'b0, irq_pulse_o}, {7'b0, exp_p});
        check("R2 status", rd_status_o, exp_status(md, ln, m_en, m_cmp));
        check("R4 compare", rd_compare_o, m_cmp);
        if (irq_pulse_o) pulse_cnt++;
        @(posedge clk);
        m_prev = lvl;
        if (we && !sel) m_en = d[6:3];
        if (we && sel)  m_cmp = d;
    endtask

    task automatic wr(logic sel, logic [7:0] d, logic [1:0] md, logic [7:0] ln,
                      string ptag);
        step(md, ln, 1'b1, sel, d, ptag);
    endtask

    task automatic idle(logic [1:0] md, logic [7:0] ln, string ptag);
        step(md, ln, 1'b0, 1'b0, 8'h00, ptag);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; mode_i = 2'd0; line_i = 8'd5;
        wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1: reset state with mode 0 on the input but nothing enabled
        check("R1 pulse", {7'b0, irq_pulse_o}, 8'h00);
        check("R1 enables", {4'b0, rd_status_o[6:3]}, 8'h00);
        check("R1 compare", rd_compare_o, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: status write with all bits set; only 6:3 land, mode/coin read live
        wr(1'b0, 8'hFF, 2'd3, 8'd9, "R3");
        idle(2'd3, 8'd9, "R3");
        check("R3 enables", {4'b0, rd_status_o[6:3]}, 8'h0F);
        check("R3 bit7", {7'b0, rd_status_o[7]}, 8'h00);
        wr(1'b0, 8'h87, 2'd3, 8'd9, "R3");
        idle(2'd3, 8'd9, "R3");
        check("R3 cleared", {4'b0, rd_status_o[6:3]}, 8'h00);

        // R4: compare write
        wr(1'b1, 8'h42, 2'd3, 8'd9, "R4");
        idle(2'd3, 8'h42, "R4");
        check("R4 cmp", rd_compare_o, 8'h42);

        // R5: no enables, cycle all modes and coincidence -> no pulse
        pulse_cnt = 0;
        for (int i = 0; i < 8; i++) idle(2'(i), 8'h42, "R5");
        check("R5 count", 8'(pulse_cnt), 8'd0);

        // R8: only mode0 enabled, 2 -> 3 -> 0 gives one request
        wr(1'b0, 8'b0000_1000, 2'd2, 8'd1, "R8");
        pulse_cnt = 0;
        idle(2'd2, 8'd1, "R8"); idle(2'd3, 8'd1, "R8");
        idle(2'd0, 8'd1, "R8"); idle(2'd0, 8'd1, "R8");
        check("R8 count", 8'(pulse_cnt), 8'd1);

        // R7: mode0+mode2 enabled, 3 -> 0 -> 2 gives exactly one
        wr(1'b0, 8'b0010_1000, 2'd3, 8'd1, "R7");
        pulse_cnt = 0;
        idle(2'd3, 8'd1, "R7"); idle(2'd0, 8'd1, "R7");
        idle(2'd2, 8'd1, "R7"); idle(2'd2, 8'd1, "R7");
        check("R7 count", 8'(pulse_cnt), 8'd1);

        // R9: mode1 true, then enabling mode1 raises request next cycle
        wr(1'b0, 8'h00, 2'd1, 8'd1, "R9");
        idle(2'd1, 8'd1, "R9");
        wr(1'b0, 8'b0001_0000, 2'd1, 8'd1, "R9");
        #0;
        idle(2'd1, 8'd1, "R9");
        check("R9 after write", 8'(pulse_cnt), 8'd2);

        // R10: single-cycle coincidence in mode 3
        wr(1'b0, 8'b0100_0000, 2'd3, 8'd1, "R10");
        pulse_cnt = 0;
        idle(2'd3, 8'd1, "R10"); idle(2'd3, 8'h42, "R10"); idle(2'd3, 8'd2, "R10");
        check("R10 count", 8'(pulse_cnt), 8'd1);

        // R11: all enabled; line held by sliding the compare value along
        wr(1'b0, 8'b0111_1000, 2'd3, 8'd1, "R11");
        pulse_cnt = 0;
        idle(2'd0, 8'd1, "R11");
        wr(1'b1, 8'd1, 2'd2, 8'd1, "R11");
        idle(2'd3, 8'd1, "R11"); idle(2'd1, 8'd1, "R11");
        idle(2'd2, 8'd1, "R11"); idle(2'd3, 8'd1, "R11");
        check("R11 held", 8'(pulse_cnt), 8'd1);
        idle(2'd3, 8'd7, "R11"); idle(2'd0, 8'd7, "R11");
        check("R11 release", 8'(pulse_cnt), 8'd2);

        // R6: random stimulus against model
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] d;
            logic       we;
            d  = 8'($urandom);
            we = ($urandom % 10) == 0;
            step(2'($urandom), 8'($urandom % 4), we, 1'($urandom), 
                 (d[0] ? d : (d & 8'h03)), "R6");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule